// File: doc/BRIEF.md
# Interrupt Presenter Register Front End

This block is the per-thread register window in front of an interrupt presenter core. It decodes 1-byte and 4-byte accesses within a 4 KB big-endian window. Each access becomes one of the following: a plain read, a read or write of scratch storage, or a one-clock action strobe to the core. The action strobes are accept, end-of-interrupt, set current priority and set IPI priority.

The core owns the pending word, whose most significant byte is the current priority. It also owns the stored IPI priority. The front end only presents these values. The same word address can behave in different ways depending on the access width and the byte lane, so the decode uses the address, the size and the direction together. An access that matches no legal combination has no side effect. It returns all ones on a read and raises an error flag.

The request side is a single-cycle interface. The response, with read data and error flag, is registered and appears exactly one clock after the request. The action strobes also appear in that cycle.

Top module: `irq_presenter_regs`

## Requirements
- R1: After reset, and again after any later reset, `rsp_valid`, `rsp_err` and all four strobes are low, and every link register reads zero.
- R2: A request accepted at a clock edge produces `rsp_valid` high for exactly the following cycle. Each strobe is high for exactly one cycle per request, and no two strobes are high together.
- R3: Word 0 (offset 0x000) is the non-destructive view. A 4-byte read returns `core_pending`. A 1-byte read with address bits [1:0] = 0 returns `core_pending[31:24]` in `rsp_rdata[7:0]`, with the upper bits zero. Neither read raises a strobe.
- R4: At offset 0x004, a 4-byte read returns `core_pending` and pulses `acc_stb`. A 1-byte read at byte 0 returns `core_pending[31:24]` in `rsp_rdata[7:0]` and does not pulse `acc_stb`.
- R5: At offset 0x004, a 1-byte write at byte 0 pulses `cprio_stb` with `prio_data` = `req_wdata[7:0]`. A 4-byte write pulses `eoi_stb` with `eoi_data` = `req_wdata`.
- R6: At offset 0x00C, only a 1-byte access at byte 0 is legal. A read returns `core_ipi_prio` in `rsp_rdata[7:0]`. A write pulses `ipi_stb` with `prio_data` = `req_wdata[7:0]`.
- R7: Offsets 0x010, 0x014 and 0x018 are three independent 32-bit link registers. Each is written and read only with 4-byte accesses.
- R8: An illegal access gives `rsp_err` = 1 and no strobe. A read then returns 0xFFFFFFFF, and a write changes nothing. Illegal accesses are: size code 2'b01 (2 bytes) or 2'b11; a 1-byte access with address bits [1:0] not zero; a 1-byte access to a link register; a 4-byte access at offset 0x00C.
- R9: An access to an unmapped word gives the same result as an illegal access. Unmapped words include any write to offset 0x000, offset 0x008, and words above 0x018. Size codes are 2'b00 = 1 byte and 2'b10 = 4 bytes, and byte 0 of a word is its most significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address in the 4 KB window |
| req_size | input | 2 | 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 reserved |
| req_wdata | input | 32 | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data; byte reads are in bits [7:0] |
| rsp_err | output | 1 | Previous request was illegal or unmapped |
| core_pending | input | 32 | Pending word from the core; top byte is current priority |
| core_ipi_prio | input | 8 | Stored IPI priority from the core |
| acc_stb | output | 1 | Accept strobe |
| eoi_stb | output | 1 | End-of-interrupt strobe |
| eoi_data | output | 32 | Value carried with the end-of-interrupt strobe |
| cprio_stb | output | 1 | Set-current-priority strobe |
| ipi_stb | output | 1 | Set-IPI-priority strobe |
| prio_data | output | 8 | Byte carried with `cprio_stb` or `ipi_stb` |

## Verification
The bench targets the places where width and lane decide the outcome.

- A design that ignored width at offset 0x004 would pulse accept on a byte read, or end-of-interrupt on a byte write, and would lose interrupts.
- A design that ignored the lane would accept a byte at lane 1 as byte 0.
- A design that ignored width on the link registers would corrupt them on a byte write. The bench shows this by reading the register back.

The bench also sends back-to-back accepts and resets in mid-run. A design that held strobes over into the next cycle, or kept link contents across reset, shows up there. Unmapped words, including writes to the poll view, must come back as all ones with the error flag and no strobe.

// File: rtl/icp_regs_pkg.sv
package icp_regs_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int PRIO_W     = 8;
    localparam int WORD_W     = ADDR_W - 2;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    localparam logic [WORD_W-1:0] WORD_POLL   = 10'd0;
    localparam logic [WORD_W-1:0] WORD_ACCEPT = 10'd1;
    localparam logic [WORD_W-1:0] WORD_IPI    = 10'd3;
    localparam logic [WORD_W-1:0] WORD_LINK0  = 10'd4;

    typedef enum logic [3:0] {
        OP_BAD,
        OP_POLL_WORD,
        OP_POLL_BYTE,
        OP_ACCEPT,
        OP_IPI_RD,
        OP_LINK_RD,
        OP_CPRIO_WR,
        OP_EOI_WR,
        OP_IPI_WR,
        OP_LINK_WR
    } op_e;

endpackage

// File: rtl/icp_access_decode.sv
module icp_access_decode
    import icp_regs_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int IDX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              write,
    output op_e               op,
    output logic [IDX_W-1:0]  link_idx
);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] rel;
    logic              byte0;
    logic              full;
    logic              in_links;

    always_comb begin
        word     = addr[ADDR_W-1:2];
        rel      = word - WORD_LINK0;
        byte0    = (size == SZ_BYTE) && (addr[1:0] == 2'b00);
        full     = (size == SZ_WORD);
        in_links = (word >= WORD_LINK0) && (rel < WORD_W'(NUM_LINKS));
        link_idx = rel[IDX_W-1:0];
        op       = OP_BAD;

        if (word == WORD_POLL) begin
            if (!write && byte0)     op = OP_POLL_BYTE;
            else if (!write && full) op = OP_POLL_WORD;
        end else if (word == WORD_ACCEPT) begin
            if (write) begin
                if (byte0)     op = OP_CPRIO_WR;
                else if (full) op = OP_EOI_WR;
            end else begin
                if (byte0)     op = OP_POLL_BYTE;
                else if (full) op = OP_ACCEPT;
            end
        end else if (word == WORD_IPI) begin
            if (byte0) op = write ? OP_IPI_WR : OP_IPI_RD;
        end else if (in_links && full) begin
            op = write ? OP_LINK_WR : OP_LINK_RD;
        end
    end

endmodule

// File: rtl/icp_link_bank.sv
module icp_link_bank #(
    parameter int NUM_LINKS = 3,
    parameter int WIDTH     = 32,
    parameter int IDX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WIDTH-1:0]               wr_data,
    output logic [NUM_LINKS-1:0][WIDTH-1:0] links
);

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        logic [WIDTH-1:0] val_d;
        logic [WIDTH-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (wr_en && (wr_idx == IDX_W'(g))) val_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign links[g] = val_q;
    end

endmodule

// File: rtl/irq_presenter_regs.sv
module irq_presenter_regs
    import icp_regs_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int IDX_W     = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [31:0]       core_pending,
    input  logic [7:0]        core_ipi_prio,
    output logic              acc_stb,
    output logic              eoi_stb,
    output logic [31:0]       eoi_data,
    output logic              cprio_stb,
    output logic              ipi_stb,
    output logic [7:0]        prio_data
);

    localparam int PAD_W = DATA_W - PRIO_W;

    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rdata;
        logic              acc;
        logic              eoi;
        logic              cprio;
        logic              ipi;
        logic [DATA_W-1:0] eoi_data;
        logic [PRIO_W-1:0] prio_data;
    } state_t;

    state_t state_d, state_q;

    op_e                              op;
    logic [IDX_W-1:0]                 link_idx;
    logic                             link_we;
    logic [NUM_LINKS-1:0][DATA_W-1:0] links;

    icp_access_decode #(
        .NUM_LINKS (NUM_LINKS),
        .IDX_W     (IDX_W)
    ) u_decode (
        .addr     (req_addr),
        .size     (req_size),
        .write    (req_write),
        .op       (op),
        .link_idx (link_idx)
    );

    assign link_we = req_valid && (op == OP_LINK_WR);

    icp_link_bank #(
        .NUM_LINKS (NUM_LINKS),
        .WIDTH     (DATA_W),
        .IDX_W     (IDX_W)
    ) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (link_we),
        .wr_idx  (link_idx),
        .wr_data (req_wdata),
        .links   (links)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_err   = 1'b0;
        state_d.rdata     = '0;
        state_d.acc       = 1'b0;
        state_d.eoi       = 1'b0;
        state_d.cprio     = 1'b0;
        state_d.ipi       = 1'b0;

        if (req_valid) begin
            unique case (op)
                OP_POLL_WORD: state_d.rdata = core_pending;
                OP_POLL_BYTE: state_d.rdata = {{PAD_W{1'b0}}, core_pending[DATA_W-1 -: PRIO_W]};
                OP_ACCEPT: begin
                    state_d.rdata = core_pending;
                    state_d.acc   = 1'b1;
                end
                OP_IPI_RD:  state_d.rdata = {{PAD_W{1'b0}}, core_ipi_prio};
                OP_LINK_RD: state_d.rdata = links[link_idx];
                OP_CPRIO_WR: begin
                    state_d.cprio     = 1'b1;
                    state_d.prio_data = req_wdata[PRIO_W-1:0];
                end
                OP_EOI_WR: begin
                    state_d.eoi      = 1'b1;
                    state_d.eoi_data = req_wdata;
                end
                OP_IPI_WR: begin
                    state_d.ipi       = 1'b1;
                    state_d.prio_data = req_wdata[PRIO_W-1:0];
                end
                OP_LINK_WR: state_d.rdata = '0;
                default: begin
                    state_d.rsp_err = 1'b1;
                    state_d.rdata   = req_write ? '0 : '1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_rdata = state_q.rdata;
    assign rsp_err   = state_q.rsp_err;
    assign acc_stb   = state_q.acc;
    assign eoi_stb   = state_q.eoi;
    assign eoi_data  = state_q.eoi_data;
    assign cprio_stb = state_q.cprio;
    assign ipi_stb   = state_q.ipi;
    assign prio_data = state_q.prio_data;

endmodule

// File: rtl/icp_regs_checker.sv
module icp_regs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [1:0]  req_size,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        acc_stb,
    input logic        eoi_stb,
    input logic [31:0] eoi_data,
    input logic        cprio_stb,
    input logic        ipi_stb,
    input logic [7:0]  prio_data
);

    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rsp_valid == $past(req_valid)));

    p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_stb, eoi_stb, cprio_stb, ipi_stb}));

    p_accept_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc_stb) |-> $past(req_valid && !req_write &&
                                     req_addr[11:2] == 10'd1 && req_size == 2'b10));

    p_eoi_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && eoi_stb) |-> ($past(req_valid && req_write && req_addr[11:2] == 10'd1 &&
                                      req_size == 2'b10) && eoi_data == $past(req_wdata)));

    p_ipi_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ipi_stb) |-> ($past(req_valid && req_write && req_addr == 12'h00C &&
                                      req_size == 2'b00) && prio_data == $past(req_wdata[7:0])));

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && !acc_stb && !eoi_stb && !cprio_stb && !ipi_stb));

    p_err_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rsp_err && $past(!req_write)) |-> (rsp_rdata == 32'hFFFF_FFFF));

endmodule

bind irq_presenter_regs icp_regs_checker u_chk (.*);

// File: tb/sim_irq_presenter_regs.sv
`timescale 1ns/1ps
module sim_irq_presenter_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [31:0] core_pending = 32'hA512_3456;
    logic [7:0]  core_ipi_prio = 8'h3C;
    logic        acc_stb, eoi_stb, cprio_stb, ipi_stb;
    logic [31:0] eoi_data;
    logic [7:0]  prio_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_presenter_regs u0 (.*);

    // stb order: {acc, eoi, cprio, ipi}
    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [31:0] rd;
        logic        err;
        logic [3:0]  stb;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 2'b10, 32'h0, 32'hA512_3456, 1'b0, 4'b0000, 8'd3}, // R3 poll word
        '{1'b0, 12'h000, 2'b00, 32'h0, 32'h0000_00A5, 1'b0, 4'b0000, 8'd3}, // R3 poll byte
        '{1'b0, 12'h004, 2'b10, 32'h0, 32'hA512_3456, 1'b0, 4'b1000, 8'd4}, // R4 accept
        '{1'b0, 12'h004, 2'b00, 32'h0, 32'h0000_00A5, 1'b0, 4'b0000, 8'd4}, // R4 byte, no accept
        '{1'b1, 12'h004, 2'b00, 32'hFFFF_FF77, 32'h0, 1'b0, 4'b0010, 8'd5}, // R5 set priority
        '{1'b1, 12'h004, 2'b10, 32'h0000_0123, 32'h0, 1'b0, 4'b0100, 8'd5}, // R5 eoi
        '{1'b0, 12'h00C, 2'b00, 32'h0, 32'h0000_003C, 1'b0, 4'b0000, 8'd6}, // R6 ipi read
        '{1'b1, 12'h00C, 2'b00, 32'h0000_005A, 32'h0, 1'b0, 4'b0001, 8'd6}, // R6 ipi write
        '{1'b1, 12'h010, 2'b10, 32'h1111_1111, 32'h0, 1'b0, 4'b0000, 8'd7}, // R7 link A
        '{1'b1, 12'h014, 2'b10, 32'h2222_2222, 32'h0, 1'b0, 4'b0000, 8'd7}, // R7 link B
        '{1'b1, 12'h018, 2'b10, 32'h3333_3333, 32'h0, 1'b0, 4'b0000, 8'd7}, // R7 link C
        '{1'b0, 12'h010, 2'b10, 32'h0, 32'h1111_1111, 1'b0, 4'b0000, 8'd7}, // R7
        '{1'b0, 12'h014, 2'b10, 32'h0, 32'h2222_2222, 1'b0, 4'b0000, 8'd7}, // R7
        '{1'b0, 12'h018, 2'b10, 32'h0, 32'h3333_3333, 1'b0, 4'b0000, 8'd7}, // R7
        '{1'b0, 12'h010, 2'b00, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd8}, // R8 byte read on link
        '{1'b1, 12'h010, 2'b00, 32'h0000_00EE, 32'h0, 1'b1, 4'b0000, 8'd8}, // R8 byte write on link
        '{1'b0, 12'h010, 2'b10, 32'h0, 32'h1111_1111, 1'b0, 4'b0000, 8'd8}, // R8 link A unchanged
        '{1'b0, 12'h005, 2'b00, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd8}, // R8 lane 1
        '{1'b0, 12'h004, 2'b01, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd8}, // R8 2-byte, no accept
        '{1'b0, 12'h004, 2'b11, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd8}, // R8 reserved size
        '{1'b0, 12'h00C, 2'b10, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd8}, // R8 word at ipi
        '{1'b1, 12'h00D, 2'b00, 32'h0000_0011, 32'h0, 1'b1, 4'b0000, 8'd8}, // R8 ipi lane 1, no strobe
        '{1'b1, 12'h000, 2'b10, 32'h0000_0456, 32'h0, 1'b1, 4'b0000, 8'd9}, // R9 write to poll view
        '{1'b0, 12'h008, 2'b10, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd9}, // R9 hole
        '{1'b0, 12'hFFC, 2'b10, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0000, 8'd9}, // R9 top word
        '{1'b1, 12'h01C, 2'b10, 32'h0000_0001, 32'h0, 1'b1, 4'b0000, 8'd9}  // R9 past links
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge register it, check at the next falling edge
    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_links_zero(input string req);
        for (int i = 0; i < 3; i++) begin
            access(1'b0, 12'h010 + 12'(4 * i), 2'b10, 32'h0);
            chk(req, "link after reset", rsp_rdata, 32'h0);
        end
    endtask

    initial begin
        do_reset();
        // R1: idle outputs right after reset
        chk("R1", "rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk("R1", "rsp_err", {31'b0, rsp_err}, 32'h0);
        chk("R1", "strobes", {28'b0, acc_stb, eoi_stb, cprio_stb, ipi_stb}, 32'h0);
        check_links_zero("R1");

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd);
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d valid", i),
                {31'b0, rsp_valid}, 32'h1);
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
                rsp_rdata, VECS[i].rd);
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d err", i),
                {31'b0, rsp_err}, {31'b0, VECS[i].err});
            chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d strobes", i),
                {28'b0, acc_stb, eoi_stb, cprio_stb, ipi_stb}, {28'b0, VECS[i].stb});
            if (VECS[i].stb[2])
                chk("R5", $sformatf("vec %0d eoi_data", i), eoi_data, VECS[i].wd);
            if (VECS[i].stb[1] || VECS[i].stb[0])
                chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d prio_data", i),
                    {24'b0, prio_data}, {24'b0, VECS[i].wd[7:0]});
        end

        // R2: back-to-back accepts give two strobes, then the idle cycle is quiet
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h004; req_size = 2'b10;
        @(negedge clk);
        chk("R2", "first accept", {30'b0, rsp_valid, acc_stb}, 32'h3);
        core_pending = 32'h0F00_0042;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "second accept", {30'b0, rsp_valid, acc_stb}, 32'h3);
        chk("R4", "second accept data", rsp_rdata, 32'h0F00_0042);
        @(negedge clk);
        chk("R2", "idle after burst", {30'b0, rsp_valid, acc_stb}, 32'h0);

        // R2: a set-priority strobe lasts one cycle
        access(1'b1, 12'h004, 2'b00, 32'h0000_0009);
        chk("R2", "cprio pulse", {31'b0, cprio_stb}, 32'h1);
        @(negedge clk);
        chk("R2", "cprio dropped", {31'b0, cprio_stb}, 32'h0);

        // R1: a reset in mid-run clears the link registers
        do_reset();
        chk("R1", "strobes after reset", {28'b0, acc_stb, eoi_stb, cprio_stb, ipi_stb}, 32'h0);
        check_links_zero("R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule